// File: doc/BRIEF.md
# Prioritized interrupt acceptance controller

This block tracks the acceptance state of 256 interrupt vectors for one processor. It keeps a pending bit array and an in-service bit array, each organised as four 64-bit words, where vector bits [7:6] choose the word and bits [5:0] choose the bit inside it. Sources raise vectors one at a time or in batches of up to all 256 at once. A task-priority register sets a mask class and a mask-everything-maskable bit. Together with the in-service state, it decides whether the highest pending vector may be taken.

Software acknowledges an interrupt with a strobe on the vector-read port. If the highest pending vector is deliverable, that vector moves from pending to in service and is returned. If it is not, a spurious code comes back. An end-of-interrupt strobe retires the highest in-service vector and asks for a fresh pending check. The block always presents the highest pending vector, the highest in-service vector and a verdict that says why the pending vector is or is not deliverable. A separate block turns these into the delivery decision and the pending hint for the core.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After reset, no vector is pending or in service, the new-pending flag is 0, the task-priority fields are 0, hi_pend_valid and hi_insvc_valid are 0, and the verdict reads 3 (idle).
- R2: A single pend with pend_vec below 256 sets pending bit pend_vec[7:0] at the next edge. hi_pend_vec then reports the highest-numbered pending vector. A pend whose pend_vec has any bit at position 8 or above set changes no state and pulses err for one cycle.
- R3: A batch pend ORs batch_bits into the pending array, with bit i standing for vector i. Single and batch pends both set new_pend. new_pend_clr clears new_pend, except in a cycle that also accepts a pend, where the flag stays set.
- R4: hi_insvc_vec and hi_insvc_valid report the highest-numbered in-service vector.
- R5: A task-priority write keeps bits [7:4] as the mask class and bit 16 as the mask-maskable bit. Every other bit has no effect on the verdict.
- R6: The verdict is encoded 0 = deliverable, 1 = masked by task priority, 2 = masked by in-service, 3 = nothing pending. When vector 2 (NMI) is the highest in service, the verdict is 2. Otherwise, when vector 2 is the highest pending, the verdict is 0 whatever the task priority.
- R7: When the highest in-service vector is 0 (ExtINT), the verdict is 2. Otherwise, when the highest pending vector is 0, the verdict is 1 if the mask-maskable bit is set and 0 if it is clear, whatever the in-service class.
- R8: For any other highest pending vector, the class is vector>>4. If nothing is in service, or the pending class exceeds the in-service class, the verdict is 0 when the mask-maskable bit is clear and the pending class exceeds the mask class, and 1 in every other case. If the pending class does not exceed the in-service class, the verdict is 2.
- R9: A vector read while the verdict is 0 returns the highest pending vector on ivr_rdata, sets its in-service bit and clears its pending bit. ivr_rvalid pulses in the cycle after the strobe.
- R10: A vector read while the verdict is not 0 returns 15 and leaves the pending and in-service state unchanged.
- R11: An end-of-interrupt clears the highest in-service bit and pulses recheck in the next cycle. With nothing in service, it changes no state, pulses err and does not pulse recheck.
- R12: When a pend and an acknowledge hit the same vector in one cycle, the vector ends up both in service and still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_valid | input | 1 | Single-vector pend strobe |
| pend_vec | input | 16 | Vector to pend; values of 256 and above are rejected |
| batch_valid | input | 1 | Batch pend strobe |
| batch_bits | input | 256 | Batch of vectors, bit i = vector i |
| new_pend_clr | input | 1 | Clears the new-pending flag |
| tpr_wr | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 64 | Task-priority write data |
| ivr_rd | input | 1 | Vector-read (acknowledge) strobe |
| ivr_rdata | output | 8 | Acknowledged vector, or 15 when spurious |
| ivr_rvalid | output | 1 | Pulses in the cycle after a vector read |
| eoi_wr | input | 1 | End-of-interrupt strobe |
| recheck | output | 1 | Pulses after a successful end-of-interrupt |
| err | output | 1 | Pulses after a rejected pend or an empty end-of-interrupt |
| new_pend | output | 1 | Sticky flag: a pend was accepted |
| hi_pend_vec | output | 8 | Highest pending vector |
| hi_pend_valid | output | 1 | Some vector is pending |
| hi_insvc_vec | output | 8 | Highest in-service vector |
| hi_insvc_valid | output | 1 | Some vector is in service |
| verdict | output | 2 | Mask verdict, encoded as in R6 |

## Verification
Every strobe is sampled on a rising edge. The state it touches, and so hi_pend_vec, hi_insvc_vec and the verdict derived from it, changes at that same edge. The registered responses ivr_rdata, ivr_rvalid, err and recheck are also valid from that edge and last one cycle. The bench drives each strobe just after a falling edge and samples all results at the following falling edge, one cycle after the stimulus. It then samples once more a cycle later to confirm that the pulses have dropped and that a spurious read or a rejected pend left the state alone.

// File: rtl/irq_acc_pkg.sv
package irq_acc_pkg;

   typedef enum logic [1:0] {
      VERD_OPEN     = 2'd0,
      VERD_BY_TPR   = 2'd1,
      VERD_BY_INSVC = 2'd2,
      VERD_IDLE     = 2'd3
   } verdict_e;

   localparam int CLASS_SHIFT = 4;
   localparam int MIC_W       = 4;

endpackage

// File: rtl/irq_word_scan.sv
module irq_word_scan #(
   parameter int W = 64,
   localparam int IW = $clog2(W)
) (
   input  logic [W-1:0]  bits,
   output logic [IW-1:0] idx,
   output logic          hit
);
   generate
      if (W < 2) begin : g_bad_w
         $error("irq_word_scan: W must be at least 2");
      end
   endgenerate

   always_comb begin
      idx = '0;
      hit = 1'b0;
      for (int i = 0; i < W; i++) begin
         if (bits[i]) begin
            idx = IW'(i);
            hit = 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_vec_scan.sv
module irq_vec_scan #(
   parameter int NUM_VEC   = 256,
   parameter int WORD_W    = 64,
   parameter bit TWO_LEVEL = 1'b1,
   localparam int VEC_W     = $clog2(NUM_VEC),
   localparam int NUM_WORDS = NUM_VEC / WORD_W,
   localparam int WB        = $clog2(WORD_W)
) (
   input  logic [NUM_VEC-1:0] bits,
   output logic [VEC_W-1:0]   vec,
   output logic               valid
);
   generate
      if (TWO_LEVEL) begin : g_two_level
         logic [WB-1:0]        w_idx [NUM_WORDS];
         logic [NUM_WORDS-1:0] w_hit;

         for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
            irq_word_scan #(.W(WORD_W)) u_scan (
               .bits (bits[w*WORD_W +: WORD_W]),
               .idx  (w_idx[w]),
               .hit  (w_hit[w])
            );
         end

         always_comb begin
            vec   = '0;
            valid = 1'b0;
            for (int w = 0; w < NUM_WORDS; w++) begin
               if (w_hit[w]) begin
                  vec   = VEC_W'(w * WORD_W) | VEC_W'(w_idx[w]);
                  valid = 1'b1;
               end
            end
         end
      end else begin : g_flat
         always_comb begin
            vec   = '0;
            valid = 1'b0;
            for (int i = 0; i < NUM_VEC; i++) begin
               if (bits[i]) begin
                  vec   = VEC_W'(i);
                  valid = 1'b1;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/irq_mask_judge.sv
module irq_mask_judge
   import irq_acc_pkg::*;
#(
   parameter int VEC_W   = 8,
   parameter int NMI_VEC = 2,
   parameter int EXT_VEC = 0,
   localparam int CLS_W  = VEC_W - CLASS_SHIFT,
   localparam int CMP_W  = (CLS_W > MIC_W) ? CLS_W : MIC_W
) (
   input  logic [VEC_W-1:0] pend_vec,
   input  logic             pend_valid,
   input  logic [VEC_W-1:0] insvc_vec,
   input  logic             insvc_valid,
   input  logic [MIC_W-1:0] mic,
   input  logic             mmi,
   output verdict_e         verdict
);
   generate
      if (VEC_W <= CLASS_SHIFT) begin : g_bad_vec_w
         $error("irq_mask_judge: VEC_W must exceed the class shift");
      end
   endgenerate

   logic [CMP_W-1:0] pend_cls, insvc_cls, mask_cls;
   logic             nmi_busy, nmi_wait, ext_busy, ext_wait;
   logic             pend_above;

   assign pend_cls  = CMP_W'(pend_vec[VEC_W-1:CLASS_SHIFT]);
   assign insvc_cls = CMP_W'(insvc_vec[VEC_W-1:CLASS_SHIFT]);
   assign mask_cls  = CMP_W'(mic);

   assign nmi_busy = insvc_valid && (insvc_vec == VEC_W'(NMI_VEC));
   assign nmi_wait = pend_valid  && (pend_vec  == VEC_W'(NMI_VEC));
   assign ext_busy = insvc_valid && (insvc_vec == VEC_W'(EXT_VEC));
   assign ext_wait = pend_valid  && (pend_vec  == VEC_W'(EXT_VEC));

   // pending ranks above service when nothing is in service or its class is higher
   assign pend_above = !insvc_valid || (pend_cls > insvc_cls);

   always_comb begin
      if (!pend_valid)      verdict = VERD_IDLE;
      else if (nmi_busy)    verdict = VERD_BY_INSVC;
      else if (nmi_wait)    verdict = VERD_OPEN;
      else if (ext_busy)    verdict = VERD_BY_INSVC;
      else if (ext_wait)    verdict = mmi ? VERD_BY_TPR : VERD_OPEN;
      else if (pend_above)  verdict = (!mmi && (pend_cls > mask_cls)) ? VERD_OPEN : VERD_BY_TPR;
      else                  verdict = VERD_BY_INSVC;
   end
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
   import irq_acc_pkg::*;
#(
   parameter int NUM_VEC        = 256,
   parameter int WORD_W         = 64,
   parameter int PEND_W         = 16,
   parameter int TPR_W          = 64,
   parameter int MIC_LSB        = 4,
   parameter int MMI_BIT        = 16,
   parameter int NMI_VEC        = 2,
   parameter int EXT_VEC        = 0,
   parameter int SPUR_VEC       = 15,
   parameter bit TWO_LEVEL_SCAN = 1'b1,
   localparam int VEC_W         = $clog2(NUM_VEC),
   localparam int NUM_WORDS     = NUM_VEC / WORD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pend_valid,
   input  logic [PEND_W-1:0]  pend_vec,
   input  logic               batch_valid,
   input  logic [NUM_VEC-1:0] batch_bits,
   input  logic               new_pend_clr,
   input  logic               tpr_wr,
   input  logic [TPR_W-1:0]   tpr_wdata,
   input  logic               ivr_rd,
   output logic [VEC_W-1:0]   ivr_rdata,
   output logic               ivr_rvalid,
   input  logic               eoi_wr,
   output logic               recheck,
   output logic               err,
   output logic               new_pend,
   output logic [VEC_W-1:0]   hi_pend_vec,
   output logic               hi_pend_valid,
   output logic [VEC_W-1:0]   hi_insvc_vec,
   output logic               hi_insvc_valid,
   output logic [1:0]         verdict
);
   // ---------------- elaboration checks ----------------
   generate
      if (NUM_VEC % WORD_W != 0) begin : g_chk_words
         $error("irq_accept_ctrl: NUM_VEC must be a multiple of WORD_W");
      end
      if (NUM_WORDS < 2) begin : g_chk_nwords
         $error("irq_accept_ctrl: at least two words are required");
      end
      if ((1 << VEC_W) != NUM_VEC) begin : g_chk_pow2
         $error("irq_accept_ctrl: NUM_VEC must be a power of two");
      end
      if (PEND_W < VEC_W) begin : g_chk_pend_w
         $error("irq_accept_ctrl: PEND_W must cover a vector");
      end
      if (MIC_LSB + MIC_W > TPR_W || MMI_BIT >= TPR_W) begin : g_chk_tpr
         $error("irq_accept_ctrl: task-priority fields exceed TPR_W");
      end
      if (SPUR_VEC >= NUM_VEC || NMI_VEC >= NUM_VEC || EXT_VEC >= NUM_VEC) begin : g_chk_codes
         $error("irq_accept_ctrl: special vectors out of range");
      end
   endgenerate

   // ---------------- state ----------------
   logic [NUM_VEC-1:0] pend_q, insvc_q;
   logic [MIC_W-1:0]   mic_q;
   logic               mmi_q;

   // ---------------- scanners and judge ----------------
   irq_vec_scan #(
      .NUM_VEC   (NUM_VEC),
      .WORD_W    (WORD_W),
      .TWO_LEVEL (TWO_LEVEL_SCAN)
   ) u_pend_scan (
      .bits  (pend_q),
      .vec   (hi_pend_vec),
      .valid (hi_pend_valid)
   );

   irq_vec_scan #(
      .NUM_VEC   (NUM_VEC),
      .WORD_W    (WORD_W),
      .TWO_LEVEL (TWO_LEVEL_SCAN)
   ) u_insvc_scan (
      .bits  (insvc_q),
      .vec   (hi_insvc_vec),
      .valid (hi_insvc_valid)
   );

   verdict_e verdict_w;

   irq_mask_judge #(
      .VEC_W   (VEC_W),
      .NMI_VEC (NMI_VEC),
      .EXT_VEC (EXT_VEC)
   ) u_judge (
      .pend_vec    (hi_pend_vec),
      .pend_valid  (hi_pend_valid),
      .insvc_vec   (hi_insvc_vec),
      .insvc_valid (hi_insvc_valid),
      .mic         (mic_q),
      .mmi         (mmi_q),
      .verdict     (verdict_w)
   );

   assign verdict = verdict_w;

   // ---------------- request decode ----------------
   logic               pend_bad, pend_ok, set_any;
   logic               ack_go, eoi_go, eoi_empty;
   logic [NUM_VEC-1:0] set_mask, ack_mask, eoi_mask;
   logic [NUM_VEC-1:0] pend_d, insvc_d;
   logic               tpr_unused;

   generate
      if (PEND_W > VEC_W) begin : g_range_chk
         assign pend_bad = |pend_vec[PEND_W-1:VEC_W];
      end else begin : g_no_range_chk
         assign pend_bad = 1'b0;
      end
   endgenerate

   assign tpr_unused = ^tpr_wdata;

   assign pend_ok   = pend_valid && !pend_bad;
   assign set_any   = pend_ok || batch_valid;
   assign ack_go    = ivr_rd && (verdict_w == VERD_OPEN);
   assign eoi_go    = eoi_wr && hi_insvc_valid;
   assign eoi_empty = eoi_wr && !hi_insvc_valid;

   always_comb begin
      set_mask = batch_valid ? batch_bits : '0;
      if (pend_ok) set_mask[pend_vec[VEC_W-1:0]] = 1'b1;
      ack_mask = '0;
      if (ack_go) ack_mask[hi_pend_vec] = 1'b1;
      eoi_mask = '0;
      if (eoi_go) eoi_mask[hi_insvc_vec] = 1'b1;
   end

   // a fresh pend on the acknowledged vector survives the acknowledge
   assign pend_d  = (pend_q & ~ack_mask) | set_mask;
   assign insvc_d = (insvc_q & ~eoi_mask) | ack_mask;

   // ---------------- registers ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q     <= '0;
         insvc_q    <= '0;
         mic_q      <= '0;
         mmi_q      <= 1'b0;
         new_pend   <= 1'b0;
         ivr_rdata  <= VEC_W'(SPUR_VEC);
         ivr_rvalid <= 1'b0;
         recheck    <= 1'b0;
         err        <= 1'b0;
      end else begin
         pend_q     <= pend_d;
         insvc_q    <= insvc_d;
         if (tpr_wr) begin
            mic_q <= tpr_wdata[MIC_LSB +: MIC_W];
            mmi_q <= tpr_wdata[MMI_BIT];
         end
         if (set_any)           new_pend <= 1'b1;
         else if (new_pend_clr) new_pend <= 1'b0;
         if (ivr_rd) ivr_rdata <= ack_go ? hi_pend_vec : VEC_W'(SPUR_VEC);
         ivr_rvalid <= ivr_rd;
         recheck    <= eoi_go;
         err        <= (pend_valid && pend_bad) || eoi_empty;
      end
   end

   // ---------------- assertions ----------------
   AST_IDLE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !hi_pend_valid |-> verdict == 2'd3);                                               // R1

   AST_BAD_VEC_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_valid && pend_vec >= PEND_W'(NUM_VEC)) |=> err);                             // R2

   AST_NEW_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_valid && pend_vec < PEND_W'(NUM_VEC)) || batch_valid) |=> new_pend);        // R3

   AST_NMI_INSVC_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_pend_valid && hi_insvc_valid && hi_insvc_vec == VEC_W'(NMI_VEC))
      |-> verdict == 2'd2);                                                              // R6

   AST_ACK_RETURNS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
      (ivr_rd && verdict == 2'd0)
      |=> (ivr_rvalid && ivr_rdata == $past(hi_pend_vec) && hi_insvc_valid));          // R9

   AST_SPUR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (ivr_rd && verdict != 2'd0 && !pend_valid && !batch_valid && !eoi_wr)
      |=> (ivr_rdata == VEC_W'(SPUR_VEC) && $stable(pend_q) && $stable(insvc_q)));      // R10

   AST_EOI_EMPTY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_wr && !hi_insvc_valid) |=> (err && !recheck));                                // R11

   AST_COLLIDE_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (ivr_rd && verdict == 2'd0 && pend_valid && pend_vec == PEND_W'(hi_pend_vec))
      |=> pend_q[$past(hi_pend_vec)]);                                                   // R12
endmodule

// File: tb/tb_irq_accept_ctrl.sv
module tb_irq_accept_ctrl;
   localparam int NV = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pend_valid = 1'b0;
   logic [15:0]   pend_vec = '0;
   logic          batch_valid = 1'b0;
   logic [NV-1:0] batch_bits = '0;
   logic          new_pend_clr = 1'b0;
   logic          tpr_wr = 1'b0;
   logic [63:0]   tpr_wdata = '0;
   logic          ivr_rd = 1'b0;
   logic [7:0]    ivr_rdata;
   logic          ivr_rvalid;
   logic          eoi_wr = 1'b0;
   logic          recheck, err, new_pend;
   logic [7:0]    hi_pend_vec, hi_insvc_vec;
   logic          hi_pend_valid, hi_insvc_valid;
   logic [1:0]    verdict;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;   // 125 MHz

   irq_accept_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .pend_valid(pend_valid), .pend_vec(pend_vec),
      .batch_valid(batch_valid), .batch_bits(batch_bits),
      .new_pend_clr(new_pend_clr),
      .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata),
      .ivr_rd(ivr_rd), .ivr_rdata(ivr_rdata), .ivr_rvalid(ivr_rvalid),
      .eoi_wr(eoi_wr), .recheck(recheck), .err(err), .new_pend(new_pend),
      .hi_pend_vec(hi_pend_vec), .hi_pend_valid(hi_pend_valid),
      .hi_insvc_vec(hi_insvc_vec), .hi_insvc_valid(hi_insvc_valid),
      .verdict(verdict)
   );

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic do_pend(input logic [15:0] v);
      pend_valid = 1'b1; pend_vec = v; tick(); pend_valid = 1'b0;
   endtask

   task automatic do_tpr(input logic [63:0] v);
      tpr_wr = 1'b1; tpr_wdata = v; tick(); tpr_wr = 1'b0;
   endtask

   task automatic do_ack();
      ivr_rd = 1'b1; tick(); ivr_rd = 1'b0;
   endtask

   task automatic do_eoi();
      eoi_wr = 1'b1; tick(); eoi_wr = 1'b0;
   endtask

   task automatic ack_expect(input string req, input logic [7:0] v);
      do_ack();
      chk(req, "ack rdata", ivr_rdata, v);
      chk(req, "ack rvalid", ivr_rvalid, 1'b1);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk("R1", "hi_pend_valid", hi_pend_valid, 1'b0);
      chk("R1", "hi_insvc_valid", hi_insvc_valid, 1'b0);
      chk("R1", "new_pend", new_pend, 1'b0);
      chk("R1", "verdict idle", verdict, 2'd3);
      chk("R1", "err", err, 1'b0);
   endtask

   task automatic t_basic();
      do_pend(16'h45);
      chk("R2", "hi_pend after pend", hi_pend_vec, 8'h45);
      chk("R2", "hi_pend_valid", hi_pend_valid, 1'b1);
      chk("R3", "new_pend set", new_pend, 1'b1);
      chk("R8", "open with no insvc", verdict, 2'd0);
      do_pend(16'h30);
      chk("R2", "highest kept", hi_pend_vec, 8'h45);
      do_pend(16'h100);
      chk("R2", "reject err pulse", err, 1'b1);
      chk("R2", "reject no change", hi_pend_vec, 8'h45);
      tick();
      chk("R2", "err drops", err, 1'b0);
      new_pend_clr = 1'b1; tick(); new_pend_clr = 1'b0;
      chk("R3", "new_pend cleared", new_pend, 1'b0);
      ack_expect("R9", 8'h45);
      chk("R4", "hi_insvc", hi_insvc_vec, 8'h45);
      chk("R9", "pend cleared", hi_pend_vec, 8'h30);
      chk("R8", "lower class masked by insvc", verdict, 2'd2);
      tick();
      chk("R9", "rvalid drops", ivr_rvalid, 1'b0);
      ack_expect("R10", 8'd15);
      chk("R10", "pend unchanged", hi_pend_vec, 8'h30);
      chk("R10", "insvc unchanged", hi_insvc_vec, 8'h45);
      do_eoi();
      chk("R11", "insvc retired", hi_insvc_valid, 1'b0);
      chk("R11", "recheck pulse", recheck, 1'b1);
      chk("R8", "open after eoi", verdict, 2'd0);
      ack_expect("R9", 8'h30);
      do_eoi();
      do_eoi();
      chk("R11", "empty eoi err", err, 1'b1);
      chk("R11", "empty eoi no recheck", recheck, 1'b0);
      chk("R1", "idle again", verdict, 2'd3);
   endtask

   task automatic t_tpr();
      do_pend(16'h52);
      do_tpr(64'h50);
      chk("R8", "class equal to mask", verdict, 2'd1);
      do_tpr(64'h40);
      chk("R8", "class above mask", verdict, 2'd0);
      do_tpr(64'h10040);
      chk("R5", "mmi bit 16 masks", verdict, 2'd1);
      do_tpr(64'hFFFF_FFFF_FFFE_FF4F);
      chk("R5", "other bits ignored", verdict, 2'd0);
      ack_expect("R9", 8'h52);
      do_eoi();
      do_tpr(64'h0);
   endtask

   task automatic t_nmi();
      do_tpr(64'h100F0);
      do_pend(16'h2);
      chk("R6", "NMI pending open", verdict, 2'd0);
      ack_expect("R6", 8'h02);
      do_pend(16'h80);
      chk("R6", "NMI insvc blocks", verdict, 2'd2);
      ack_expect("R10", 8'd15);
      do_eoi();
      chk("R8", "mmi masks after eoi", verdict, 2'd1);
      do_tpr(64'h0);
      chk("R8", "open after tpr clear", verdict, 2'd0);
      ack_expect("R9", 8'h80);
      do_eoi();
   endtask

   task automatic t_ext();
      do_tpr(64'h10000);
      do_pend(16'h0);
      chk("R7", "ExtINT pending valid", hi_pend_valid, 1'b1);
      chk("R7", "ExtINT masked by mmi", verdict, 2'd1);
      do_tpr(64'h0);
      chk("R7", "ExtINT open", verdict, 2'd0);
      ack_expect("R7", 8'h00);
      do_pend(16'h90);
      chk("R7", "ExtINT insvc blocks", verdict, 2'd2);
      do_eoi();
      chk("R7", "open after ExtINT eoi", verdict, 2'd0);
      ack_expect("R9", 8'h90);
      do_eoi();
      do_pend(16'h40);
      ack_expect("R9", 8'h40);
      do_pend(16'h0);
      chk("R7", "ExtINT open below insvc class", verdict, 2'd0);
      ack_expect("R7", 8'h00);
      chk("R4", "highest insvc", hi_insvc_vec, 8'h40);
      do_eoi();
      chk("R11", "eoi retires highest", hi_insvc_vec, 8'h00);
      do_eoi();
      chk("R11", "all retired", hi_insvc_valid, 1'b0);
   endtask

   task automatic t_collide();
      do_pend(16'h61);
      pend_valid = 1'b1; pend_vec = 16'h61; ivr_rd = 1'b1;
      tick();
      pend_valid = 1'b0; ivr_rd = 1'b0;
      chk("R12", "ack rdata", ivr_rdata, 8'h61);
      chk("R12", "insvc set", hi_insvc_vec, 8'h61);
      chk("R12", "still pending", hi_pend_valid, 1'b1);
      chk("R12", "pending vec", hi_pend_vec, 8'h61);
      chk("R8", "same class blocked", verdict, 2'd2);
      do_eoi();
      ack_expect("R12", 8'h61);
      do_eoi();
   endtask

   task automatic t_batch();
      logic [NV-1:0] b;
      new_pend_clr = 1'b1; tick(); new_pend_clr = 1'b0;
      b = '0; b[3] = 1'b1; b[70] = 1'b1; b[200] = 1'b1;
      batch_valid = 1'b1; batch_bits = b; tick(); batch_valid = 1'b0;
      chk("R3", "batch highest", hi_pend_vec, 8'd200);
      chk("R3", "batch new_pend", new_pend, 1'b1);
      pend_valid = 1'b1; pend_vec = 16'h5; new_pend_clr = 1'b1;
      tick();
      pend_valid = 1'b0; new_pend_clr = 1'b0;
      chk("R3", "pend wins over clear", new_pend, 1'b1);
      ack_expect("R9", 8'd200);
      chk("R3", "next batch vector", hi_pend_vec, 8'd70);
      chk("R8", "below insvc class", verdict, 2'd2);
      do_eoi();
      ack_expect("R9", 8'd70);
      do_eoi();
      chk("R2", "single pend kept", hi_pend_vec, 8'd5);
      chk("R8", "class 0 not above mask 0", verdict, 2'd1);
      ack_expect("R10", 8'd15);
      chk("R10", "pending kept", hi_pend_vec, 8'd5);
      chk("R10", "insvc kept empty", hi_insvc_valid, 1'b0);
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_basic();
      t_tpr();
      t_nmi();
      t_ext();
      t_collide();
      t_batch();
      report();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL all watchdog: actual=timeout expected=done");
      report();
      $finish;
   end
endmodule